// File: doc/BRIEF.md
# Sector Word Transfer Sequencer

This block runs the data phase of a single disk sector record. A start pulse arrives with a transfer type, a word count and a starting memory address. The block first handles the sync word: it sends the sync word when writing, and it waits for one on the incoming disk stream when reading or checking. It then makes one pass per word. Each pass decrements the count, selects the next lower memory address, and performs the memory and disk moves that the transfer type calls for.

Check mode compares memory against the disk. A memory word that is non-zero and differs from the disk word ends the sector at once, with an error. A memory word of zero is filled with the disk word. A running checksum covers every data word. It is sent after the data when writing and compared against the disk when reading or checking. A checksum mismatch is only flagged.

After the checksum comes a finishing delay that depends on the operation. The block then pulses `done`, advances the record number and goes back to idle. The memory port, the incoming disk word stream and the outgoing disk word stream all use simple valid/ready style handshakes.

Top module: `sector_xfer_seq`

## Requirements
- R1: `start` while idle latches `xfer_type` (00 = read, 01 = check, 10 = write, 11 = none) and makes `busy` high. `start` while busy is ignored. While idle, `mem_req`, `dout_valid` and `din_ready` stay low.
- R2: In write mode, the first word accepted on `dout` is `SYNC_WORD`. In read and check modes, incoming disk words are consumed and discarded until one equals `SYNC_WORD`.
- R3: Word pass i (counting from 0) uses memory address `base_addr - i`. The block makes exactly `word_count` passes, and a count of 0 goes straight to the checksum.
- R4: In read mode, the i-th data word after the sync is written to memory address `base_addr - i`.
- R5: In write mode, the word read from address `base_addr - i` is the (i+1)-th word sent on `dout`, after the sync word.
- R6: In check mode, a memory word equal to the disk word causes no memory write. A memory word of zero is overwritten with the disk word.
- R7: In check mode, a non-zero memory word that differs from the disk word sets `st_abort` and ends the sector. No further memory access or disk word follows, the checksum word is not consumed, and `done` still pulses.
- R8: The checksum is `CK_SEED` XOR every data word. In write mode it is sent after the last data word. In read and check modes it is compared with the next incoming word, and a mismatch sets `st_ck_err` while the sector completes normally.
- R9: `done` is high exactly D+2 cycles after the cycle in which the checksum word is transferred. D is `DLY_RD`, `DLY_CK` or `DLY_WR`, depending on the transfer type.
- R10: `done` lasts one cycle, and `rec_no` increments by one with each `done` and at no other time. `st_abort` and `st_ck_err` are cleared by an accepted start.
- R11: Type 11 makes no memory, disk input or disk output transfer. `done` is high in the cycle after the start is taken.
- R12: A pending memory request keeps `mem_req`, `mem_addr` and `mem_we` steady until `mem_ack`. A pending outgoing word keeps `dout_valid` and `dout_data` steady until `dout_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sector (taken only while idle) |
| xfer_type | input | 2 | 00 read, 01 check, 10 write, 11 none |
| word_count | input | CW | Number of data words |
| base_addr | input | AW | Highest memory address of the record |
| busy | output | 1 | Sector in progress |
| done | output | 1 | One-cycle end-of-sector pulse |
| st_abort | output | 1 | Check-mode compare failure |
| st_ck_err | output | 1 | Checksum mismatch |
| rec_no | output | RW | Record number |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |
| din_valid | input | 1 | Incoming disk word valid |
| din_data | input | 16 | Incoming disk word |
| din_ready | output | 1 | Block accepts incoming disk word |
| dout_valid | output | 1 | Outgoing disk word valid |
| dout_data | output | 16 | Outgoing disk word |
| dout_ready | input | 1 | Disk side accepts outgoing word |

## Verification
The failure modes below show up at the ports in different ways:

- A word counter or address register that is off by one shows up on the first sector. Memory is written at a shifted address, or one word too many or too few is transferred, and the checksum word then lands in the wrong slot.
- A wrong transfer-type decode shows up at once, because the wrong handshake becomes active right after the sync.
- A checksum register that is not seeded or updated correctly shows up only at the end of a sector, as a spurious `st_ck_err` or a wrong final word on `dout`.
- A delay counter that loads the wrong table entry shifts `done` by a whole number of cycles measured from the checksum handshake.

// File: rtl/sxs_pkg.sv
package sxs_pkg;

  localparam int SXS_DW = 16;

  typedef enum logic [1:0] {
    XT_READ  = 2'b00,
    XT_CHECK = 2'b01,
    XT_WRITE = 2'b10,
    XT_NONE  = 2'b11
  } xtype_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SYNC, S_WORD, S_MRD, S_DRD, S_MWR, S_DOUT, S_CKS, S_DLY, S_FIN
  } st_e;

  // running checksum step
  function automatic logic [SXS_DW-1:0] cks_fold(input logic [SXS_DW-1:0] acc,
                                                 input logic [SXS_DW-1:0] w);
    return acc ^ w;
  endfunction

  // check-mode verdict: memory word present and disagreeing with disk
  function automatic logic chk_conflict(input logic [SXS_DW-1:0] mw,
                                        input logic [SXS_DW-1:0] dw);
    return (mw != '0) && (mw != dw);
  endfunction

endpackage

// File: rtl/sxs_wcnt.sv
module sxs_wcnt #(
  parameter int CW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] n_in,
  input  logic [AW-1:0] base_in,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic          last
);
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] nxt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      nxt_q    <= '0;
      cur_addr <= '0;
    end else if (load) begin
      cnt_q <= n_in;
      nxt_q <= base_in;
    end else if (step) begin
      cnt_q    <= cnt_q - 1'b1;
      cur_addr <= nxt_q;
      nxt_q    <= nxt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/sxs_cksum.sv
module sxs_cksum
  import sxs_pkg::*;
#(
  parameter logic [SXS_DW-1:0] SEED = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              upd,
  input  logic [SXS_DW-1:0] word,
  output logic [SXS_DW-1:0] sum
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sum <= SEED;
    else if (clear) sum <= SEED;
    else if (upd)   sum <= cks_fold(sum, word);
  end
endmodule

// File: rtl/sxs_dly.sv
module sxs_dly #(
  parameter int W    = 6,
  parameter int D_RD = 3,
  parameter int D_CK = 4,
  parameter int D_WR = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] sel,
  output logic       expired
);
  localparam logic [W-1:0] TBL [4] = '{W'(D_RD), W'(D_CK), W'(D_WR), '0};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= TBL[sel];
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sector_xfer_seq.sv
module sector_xfer_seq
  import sxs_pkg::*;
#(
  parameter int                AW        = 8,
  parameter int                CW        = 8,
  parameter int                RW        = 8,
  parameter logic [SXS_DW-1:0] SYNC_WORD = 16'h8001,
  parameter logic [SXS_DW-1:0] CK_SEED   = 16'h5A3C,
  parameter int                DLYW      = 6,
  parameter int                DLY_RD    = 3,
  parameter int                DLY_CK    = 4,
  parameter int                DLY_WR    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        xfer_type,
  input  logic [CW-1:0]     word_count,
  input  logic [AW-1:0]     base_addr,
  output logic              busy,
  output logic              done,
  output logic              st_abort,
  output logic              st_ck_err,
  output logic [RW-1:0]     rec_no,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [SXS_DW-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [SXS_DW-1:0] mem_rdata,
  input  logic              din_valid,
  input  logic [SXS_DW-1:0] din_data,
  output logic              din_ready,
  output logic              dout_valid,
  output logic [SXS_DW-1:0] dout_data,
  input  logic              dout_ready
);
  st_e               st_q, st_d;
  xtype_e            xt_q;
  logic [SXS_DW-1:0] mword_q, dword_q, sum;
  logic              wc_last, dly_exp, is_wr;

  // named internal events
  logic ev_start, ev_din, ev_dout, ev_mem, ev_abort, ev_ck_fail, ev_cks_done;
  logic ck_upd;
  logic [SXS_DW-1:0] ck_word;

  assign is_wr    = (xt_q == XT_WRITE);
  assign ev_start = start && (st_q == S_IDLE);
  assign ev_din   = din_valid && din_ready;
  assign ev_dout  = dout_valid && dout_ready;
  assign ev_mem   = mem_req && mem_ack;

  assign busy       = (st_q != S_IDLE);
  assign done       = (st_q == S_FIN);
  assign din_ready  = ((st_q == S_SYNC) && !is_wr) || (st_q == S_DRD) ||
                      ((st_q == S_CKS) && !is_wr);
  assign dout_valid = ((st_q == S_SYNC) && is_wr) || (st_q == S_DOUT) ||
                      ((st_q == S_CKS) && is_wr);
  assign dout_data  = (st_q == S_SYNC) ? SYNC_WORD :
                      (st_q == S_CKS)  ? sum : mword_q;
  assign mem_req    = (st_q == S_MRD) || (st_q == S_MWR);
  assign mem_we     = (st_q == S_MWR);
  assign mem_wdata  = dword_q;

  assign ev_abort    = (st_q == S_DRD) && ev_din && (xt_q == XT_CHECK) &&
                       chk_conflict(mword_q, din_data);
  assign ev_cks_done = (st_q == S_CKS) && (is_wr ? ev_dout : ev_din);
  assign ev_ck_fail  = (st_q == S_CKS) && !is_wr && ev_din && (din_data != sum);

  assign ck_upd  = ((st_q == S_MRD) && ev_mem && is_wr) || ((st_q == S_DRD) && ev_din);
  assign ck_word = (st_q == S_MRD) ? mem_rdata : din_data;

  sxs_wcnt #(.CW(CW), .AW(AW)) u_wcnt (
    .clk(clk), .rst_n(rst_n), .load(ev_start), .n_in(word_count),
    .base_in(base_addr), .step(st_q == S_WORD), .cur_addr(mem_addr), .last(wc_last)
  );

  sxs_cksum #(.SEED(CK_SEED)) u_cks (
    .clk(clk), .rst_n(rst_n), .clear(ev_start), .upd(ck_upd),
    .word(ck_word), .sum(sum)
  );

  sxs_dly #(.W(DLYW), .D_RD(DLY_RD), .D_CK(DLY_CK), .D_WR(DLY_WR)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(ev_cks_done), .sel(xt_q), .expired(dly_exp)
  );

  always_comb begin
    st_e after_word;
    after_word = wc_last ? S_CKS : S_WORD;
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (start) st_d = (xtype_e'(xfer_type) == XT_NONE) ? S_FIN : S_SYNC;
      S_SYNC: begin
        if (is_wr) begin
          if (ev_dout) st_d = after_word;
        end else if (ev_din && (din_data == SYNC_WORD)) begin
          st_d = after_word;
        end
      end
      S_WORD: st_d = (xt_q == XT_READ) ? S_DRD : S_MRD;
      S_MRD:  if (ev_mem) st_d = is_wr ? S_DOUT : S_DRD;
      S_DRD: begin
        if (ev_din) begin
          if (xt_q == XT_READ)         st_d = S_MWR;
          else if (ev_abort)           st_d = S_FIN;
          else if (mword_q == '0)      st_d = S_MWR;
          else                         st_d = after_word;
        end
      end
      S_MWR:  if (ev_mem) st_d = after_word;
      S_DOUT: if (ev_dout) st_d = after_word;
      S_CKS:  if (ev_cks_done) st_d = S_DLY;
      S_DLY:  if (dly_exp) st_d = S_FIN;
      S_FIN:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      xt_q      <= XT_READ;
      mword_q   <= '0;
      dword_q   <= '0;
      st_abort  <= 1'b0;
      st_ck_err <= 1'b0;
      rec_no    <= '0;
    end else begin
      st_q <= st_d;
      if (ev_start) begin
        xt_q      <= xtype_e'(xfer_type);
        st_abort  <= 1'b0;
        st_ck_err <= 1'b0;
      end
      if (ev_mem && !mem_we)              mword_q <= mem_rdata;
      if ((st_q == S_DRD) && ev_din)      dword_q <= din_data;
      if (ev_abort)                       st_abort <= 1'b1;
      if (ev_ck_fail)                     st_ck_err <= 1'b1;
      if (st_q == S_FIN)                  rec_no <= rec_no + 1'b1;
    end
  end
endmodule

// File: rtl/sxs_chk.sv
module sxs_chk #(
  parameter int AW = 8,
  parameter int RW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          st_abort,
  input logic [RW-1:0] rec_no,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          din_ready,
  input logic          dout_valid,
  input logic [15:0]   dout_data,
  input logic          dout_ready
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !dout_valid && !din_ready));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  rec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (rec_no == $past(rec_no) + 1'b1));

  // R10
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(rec_no));

  // R7
  abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_abort) |-> (done && !mem_req && !din_ready));

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R12
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));
endmodule

bind sector_xfer_seq sxs_chk #(.AW(AW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .st_abort(st_abort),
  .rec_no(rec_no), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .din_ready(din_ready), .dout_valid(dout_valid),
  .dout_data(dout_data), .dout_ready(dout_ready)
);

// File: tb/sim_sector_xfer_seq.sv
module sim_sector_xfer_seq;
  localparam logic [15:0] SYNC = 16'h8001;
  localparam logic [15:0] SEED = 16'h5A3C;
  localparam int D_RD = 3, D_CK = 4, D_WR = 6;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] xfer_type = 0;
  logic [7:0] word_count = 0, base_addr = 0;
  logic busy, done, st_abort, st_ck_err, mem_req, mem_we, din_ready, dout_valid;
  logic [7:0] rec_no, mem_addr;
  logic [15:0] mem_wdata, mem_rdata, dout_data;
  logic mem_ack = 0, din_valid = 0, dout_ready = 0;
  logic [15:0] din_data = 0;

  logic [15:0] mem [256];
  logic [15:0] dq [64];
  logic [15:0] oq [64];
  int dq_n = 0, dq_i = 0, oq_n = 0, wr_cnt = 0, cyc = 0, hs_cyc = 0;
  int errors = 0, checks = 0, rec_exp = 0;

  always #5 clk = ~clk;

  sector_xfer_seq #(.SYNC_WORD(SYNC), .CK_SEED(SEED), .DLY_RD(D_RD),
                    .DLY_CK(D_CK), .DLY_WR(D_WR)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_type(xfer_type),
    .word_count(word_count), .base_addr(base_addr), .busy(busy), .done(done),
    .st_abort(st_abort), .st_ck_err(st_ck_err), .rec_no(rec_no),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .din_valid(din_valid),
    .din_data(din_data), .din_ready(din_ready), .dout_valid(dout_valid),
    .dout_data(dout_data), .dout_ready(dout_ready)
  );

  assign mem_rdata = mem[mem_addr];

  // environment bookkeeping on the clock edge (pre-edge values)
  always @(posedge clk) begin
    if (din_valid && din_ready) begin dq_i++; hs_cyc = cyc; end
    if (dout_valid && dout_ready) begin oq[oq_n] = dout_data; oq_n++; hs_cyc = cyc; end
    if (mem_req && mem_ack && mem_we) begin mem[mem_addr] = mem_wdata; wr_cnt++; end
    cyc++;
  end

  // stalling handshake partners
  always @(negedge clk) begin
    din_valid  = (dq_i < dq_n) && ((cyc % 4) != 3);
    din_data   = (dq_i < dq_n) ? dq[dq_i] : 16'h0;
    dout_ready = (cyc % 5) != 2;
    mem_ack    = (cyc % 3) != 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] dword(input int k, input int i);
    return (16'h2B10 + 16'(k * 16'h0111) + 16'(i * 16'h1357)) | 16'h0010;
  endfunction

  task automatic run(input logic [1:0] xt, input int n, input int base,
                     input bit glitch, output int lat, output int ncyc);
    int k;
    @(negedge clk);
    dq_i = 0; oq_n = 0; wr_cnt = 0;
    xfer_type = xt; word_count = 8'(n); base_addr = 8'(base); start = 1;
    @(negedge clk);
    start = 0; k = 1;
    while (!done && k < 3000) begin
      @(negedge clk);
      k++;
      if (glitch && k == 4) begin start = 1; xfer_type = 2'b00; end
      else start = 0;
    end
    chk(k < 3000, "watchdog", k, 0);
    lat = cyc - hs_cyc; ncyc = k;
    rec_exp = (rec_exp + 1) % 256;
    chk(rec_no == 8'(rec_exp - 1), "R10 rec before", rec_no, rec_exp - 1);
    @(negedge clk);
    chk(!done && rec_no == 8'(rec_exp), "R10 done pulse/rec_no", {done, rec_no}, rec_exp);
  endtask

  // disk stream: junk, junk, sync, n words of seed k, checksum (+bad flips it)
  task automatic load_disk(input int k, input int n, input bit bad);
    logic [15:0] c;
    c = SEED;
    dq[0] = 16'h1234; dq[1] = 16'h0000; dq[2] = SYNC;
    for (int i = 0; i < n; i++) begin dq[3 + i] = dword(k, i); c ^= dword(k, i); end
    dq[3 + n] = bad ? ~c : c;
    dq_n = n + 4;
  endtask

  initial begin
    int lat, nc, base;
    logic [15:0] c, saved [8];
    for (int a = 0; a < 256; a++) mem[a] = 16'hDEAD;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && rec_no == 0, "R1 reset", {busy, done, rec_no}, 0);
    chk(!mem_req && !dout_valid && !din_ready, "R1 reset quiet",
        {mem_req, dout_valid, din_ready}, 0);
    rst_n = 1;

    // R8 bad checksum on a read: flagged, sector still completes
    load_disk(9, 3, 1);
    run(2'b00, 3, 20, 0, lat, nc);
    chk(st_ck_err && !st_abort, "R8 ck_err flagged", {st_ck_err, st_abort}, 2);
    chk(wr_cnt == 3 && mem[18] == dword(9, 2), "R8 data kept", mem[18], dword(9, 2));

    // R2 R3 R4 R9 R10 read sweep, counts 0..5
    for (int n = 0; n < 6; n++) begin
      base = 40 + n * 7;
      load_disk(n, n, 0);
      run(2'b00, n, base, 0, lat, nc);
      chk(dq_i == dq_n, "R2 junk skipped, all consumed", dq_i, dq_n);
      chk(wr_cnt == n, "R3 pass count", wr_cnt, n);
      for (int i = 0; i < n; i++)
        chk(mem[base - i] == dword(n, i), "R4 read data", mem[base - i], dword(n, i));
      chk(mem[base + 1] == 16'hDEAD && mem[base - n] == 16'hDEAD, "R3 bounds",
          mem[base - n], 16'hDEAD);
      chk(!st_ck_err && !st_abort, "R10 status cleared", {st_ck_err, st_abort}, 0);
      chk(lat == D_RD + 2, "R9 read delay", lat, D_RD + 2);
    end

    // R2 R5 R8 R9 write sweep
    for (int n = 0; n < 6; n++) begin
      base = 150 + n * 8;
      for (int i = 0; i < n; i++) mem[base - i] = dword(20 + n, i);
      dq_n = 0;
      run(2'b10, n, base, 0, lat, nc);
      c = SEED;
      chk(oq_n == n + 2 && oq[0] == SYNC, "R2 write sync", oq[0], SYNC);
      for (int i = 0; i < n; i++) begin
        chk(oq[1 + i] == dword(20 + n, i), "R5 write data", oq[1 + i], dword(20 + n, i));
        c ^= dword(20 + n, i);
      end
      chk(oq[n + 1] == c, "R8 write checksum", oq[n + 1], c);
      chk(wr_cnt == 0, "R5 no memory writes", wr_cnt, 0);
      chk(lat == D_WR + 2, "R9 write delay", lat, D_WR + 2);
    end

    // R6 check with fill and match
    base = 100;
    for (int i = 0; i < 6; i++) mem[base - i] = (i % 2 == 0) ? 16'h0 : dword(40, i);
    load_disk(40, 6, 0);
    run(2'b01, 6, base, 0, lat, nc);
    chk(wr_cnt == 3, "R6 only zero words written", wr_cnt, 3);
    for (int i = 0; i < 6; i++)
      chk(mem[base - i] == dword(40, i), "R6 check result", mem[base - i], dword(40, i));
    chk(!st_abort && !st_ck_err && dq_i == dq_n, "R8 check checksum ok",
        {st_abort, st_ck_err}, 0);
    chk(lat == D_CK + 2, "R9 check delay", lat, D_CK + 2);

    // R7 check abort at word 2
    base = 120;
    for (int i = 0; i < 6; i++) mem[base - i] = dword(50, i);
    mem[base] = 16'h0;
    mem[base - 2] = 16'h7777;
    for (int i = 0; i < 6; i++) saved[i] = mem[base - i];
    load_disk(50, 6, 0);
    run(2'b01, 6, base, 0, lat, nc);
    chk(st_abort, "R7 abort flag", st_abort, 1);
    chk(wr_cnt == 1 && mem[base] == dword(50, 0), "R7 fill before abort", wr_cnt, 1);
    chk(dq_i == 6, "R7 no further disk words", dq_i, 6);
    for (int i = 2; i < 6; i++)
      chk(mem[base - i] == saved[i], "R7 memory untouched", mem[base - i], saved[i]);

    // R11 no-transfer type
    dq_n = 0;
    run(2'b11, 5, 60, 0, lat, nc);
    chk(nc == 1, "R11 immediate done", nc, 1);
    chk(wr_cnt == 0 && oq_n == 0 && dq_i == 0, "R11 nothing moved",
        {wr_cnt[7:0], oq_n[7:0]}, 0);
    chk(!st_abort, "R10 abort cleared by start", st_abort, 0);

    // R1 start ignored while busy
    base = 90;
    for (int i = 0; i < 3; i++) mem[base - i] = dword(60, i);
    dq_n = 0;
    run(2'b10, 3, base, 1, lat, nc);
    chk(oq_n == 5 && oq[3] == dword(60, 2) && wr_cnt == 0, "R1 restart ignored",
        oq_n, 5);
    repeat (3) @(negedge clk);
    chk(!busy && rec_no == 8'(rec_exp), "R1 single sector", rec_no, rec_exp);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule